// File: doc/BRIEF.md
# DS3 AIS and Idle Signal Generator

This block sits in a DS3 C-bit transmit path and replaces the outgoing serial bit stream with either the Alarm Indication Signal or the Idle signal. It keeps its own position inside the 4760-bit M-frame: seven subframes of eight 85-bit blocks, each block one overhead bit followed by 84 payload bits. A frame-start strobe aligns that count to the stream. For each bit the block knows whether it is payload or which overhead bit it is, and rewrites it.

In either signal mode the payload becomes a fixed four-bit pattern whose phase restarts after every overhead bit. The multiframe bits, subframe bits and parity bits are rewritten: the parity bits take the parity value supplied from upstream for the previous output frame. AIS also forces the X-bits high and clears the C-bits of every subframe except the third. AIS wins when both controls are asserted. The controls are sampled only at the first bit of an M-frame, so a frame is never sent with mixed content.

The block accepts one bit on each clock in which `bitEn` is high and presents the rewritten bit on `dataOut` one clock later.

Top module: `ds3_fill_gen`

## Requirements
- R1: With neither mode latched, `dataOut` equals the `dataIn` of the previous accepted bit (one-clock latency). `dataOut` holds its value in clocks with `bitEn` low. `dataOut` is 0 after reset.
- R2: Bit position 0 is the first X-bit of the frame. Position 0 is forced by `frameStart` on an accepted bit, and is also reached by wrapping after 4760 bits. Within the frame, position p lies in subframe p/680 and block (p/85)%8, with overhead at p%85 = 0.
- R3: In Idle mode, payload bit k (k = p%85 - 1, from 0 to 83) is 1 when k%4 is 0 or 1 and is 0 otherwise.
- R4: In AIS mode, payload bit k is 1 when k is even and 0 when k is odd.
- R5: In either mode, the block-0 overhead bits of subframes 5, 6 and 7 are 0, 1 and 0.
- R6: In either mode, the overhead bits of blocks 1, 3, 5 and 7 of every subframe are 1, 0, 0 and 1.
- R7: In either mode, the block-0 overhead bits of subframes 3 and 4 carry the `parityIn` value presented with that bit.
- R8: The block-0 overhead bits of subframes 1 and 2 are 1 in AIS mode and pass `dataIn` in Idle mode.
- R9: The overhead bits of blocks 2, 4 and 6 are 0 in AIS mode, except in subframe 3, where they pass `dataIn`. In Idle mode these bits pass `dataIn` in all subframes.
- R10: When `aisEn` and `idleEn` are both high at a frame start, the frame carries AIS.
- R11: The mode (pass, Idle or AIS) is sampled from `aisEn` and `idleEn` only on the accepted bit at position 0. A change at any other time has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One stream bit is accepted on this clock |
| frameStart | input | 1 | The accepted bit is the first bit of an M-frame |
| dataIn | input | 1 | Incoming stream bit |
| parityIn | input | 1 | Payload parity of the previous output frame |
| aisEn | input | 1 | Request AIS |
| idleEn | input | 1 | Request Idle |
| dataOut | output | 1 | Rewritten stream bit, one clock after acceptance |

## Verification
The checker asserts the following on every accepted bit, in terms of the decoded slot and the latched mode:
- pass-through, and holding while `bitEn` is low;
- both payload patterns;
- parity-bit substitution and the AIS X-bits;
- AIS priority at a frame boundary;
- that the mode never changes mid-frame.

Only the bench's scenarios can show the rest, because it follows from the frame counting itself:
- that fixed overhead values land on the right frame positions;
- that the count wraps at 4760 and resynchronises on `frameStart`;
- that C-bits in subframe 3 survive AIS.

// File: rtl/ds3_fill_pkg.sv
package ds3_fill_pkg;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_AIS  = 2'd2
  } fillMode_e;

  typedef enum logic [2:0] {
    SLOT_PAY = 3'd0,
    SLOT_X   = 3'd1,
    SLOT_P   = 3'd2,
    SLOT_M   = 3'd3,
    SLOT_F   = 3'd4,
    SLOT_C   = 3'd5
  } slot_e;

  // Strobes from control to datapath, valid for the bit being accepted.
  typedef struct packed {
    logic      adv;     // bit accepted this clock
    logic      sof;     // accepted bit is frame position 0
    slot_e     slot;    // what the bit is
    logic      fixVal;  // fixed value for M and F slots
    logic [1:0] phase;  // payload index modulo 4
    logic      cKeep;   // C-bits of this subframe survive AIS
    fillMode_e mode;    // mode applied to this bit
  } fillStrobe_t;

endpackage

// File: rtl/ds3_fill_ctrl.sv
module ds3_fill_ctrl
  import ds3_fill_pkg::*;
#(
  parameter int BLOCK_LEN  = 85,
  parameter int BLOCKS     = 8,
  parameter int SUBFRAMES  = 7,
  parameter int X_SUBS     = 2,
  parameter int P_SUBS     = 2,
  parameter int KEEP_C_SUB = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitEn,
  input  logic        frameStart,
  input  logic        aisEn,
  input  logic        idleEn,
  output fillStrobe_t strb
);

  localparam int BW = $clog2(BLOCK_LEN);
  localparam int KW = $clog2(BLOCKS);
  localparam int SW = $clog2(SUBFRAMES);
  localparam logic [BW-1:0] BIT_LAST = BW'(BLOCK_LEN - 1);
  localparam logic [KW-1:0] BLK_LAST = KW'(BLOCKS - 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBFRAMES - 1);
  localparam logic [SW-1:0] P_FIRST  = SW'(X_SUBS);
  localparam logic [SW-1:0] M_FIRST  = SW'(X_SUBS + P_SUBS);
  localparam logic [SW-1:0] M_ONE    = SW'(X_SUBS + P_SUBS + 1);
  localparam logic [SW-1:0] C_KEEP   = SW'(KEEP_C_SUB);
  localparam logic [KW-1:0] F_LAST   = KW'(BLOCKS / 2 - 1);

  logic [BW-1:0] bitCnt, curBit, payOff;
  logic [KW-1:0] blkCnt, curBlk, fIdx;
  logic [SW-1:0] subCnt, curSub;
  fillMode_e     modeReg, selMode;
  logic          atFrame0;

  // effective position of the bit on the input this clock
  assign curBit   = frameStart ? '0 : bitCnt;
  assign curBlk   = frameStart ? '0 : blkCnt;
  assign curSub   = frameStart ? '0 : subCnt;
  assign atFrame0 = (curBit == '0) && (curBlk == '0) && (curSub == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      blkCnt <= '0;
      subCnt <= '0;
    end else if (bitEn) begin
      if (curBit == BIT_LAST) begin
        bitCnt <= '0;
        if (curBlk == BLK_LAST) begin
          blkCnt <= '0;
          subCnt <= (curSub == SUB_LAST) ? '0 : curSub + SW'(1);
        end else begin
          blkCnt <= curBlk + KW'(1);
          subCnt <= curSub;
        end
      end else begin
        bitCnt <= curBit + BW'(1);
        blkCnt <= curBlk;
        subCnt <= curSub;
      end
    end
  end

  always_comb begin
    if (aisEn)       selMode = MODE_AIS;
    else if (idleEn) selMode = MODE_IDLE;
    else             selMode = MODE_PASS;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  modeReg <= MODE_PASS;
    else if (bitEn && atFrame0) modeReg <= selMode;
  end

  assign payOff = curBit - BW'(1);
  assign fIdx   = curBlk >> 1;

  always_comb begin
    strb.adv    = bitEn;
    strb.sof    = bitEn && atFrame0;
    strb.mode   = atFrame0 ? selMode : modeReg;
    strb.phase  = payOff[1:0];
    strb.cKeep  = (curSub == C_KEEP);
    strb.fixVal = 1'b0;
    if (curBit != '0) begin
      strb.slot = SLOT_PAY;
    end else if (curBlk[0]) begin
      strb.slot   = SLOT_F;
      strb.fixVal = (fIdx == '0) || (fIdx == F_LAST);
    end else if (curBlk == '0) begin
      if (curSub < P_FIRST) begin
        strb.slot = SLOT_X;
      end else if (curSub < M_FIRST) begin
        strb.slot = SLOT_P;
      end else begin
        strb.slot   = SLOT_M;
        strb.fixVal = (curSub == M_ONE);
      end
    end else begin
      strb.slot = SLOT_C;
    end
  end

endmodule

// File: rtl/ds3_fill_dp.sv
module ds3_fill_dp
  import ds3_fill_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  fillStrobe_t strb,
  input  logic        dataIn,
  input  logic        parityIn,
  output logic        dataOut
);

  logic nxtBit;
  logic isAis;

  assign isAis = (strb.mode == MODE_AIS);

  always_comb begin
    nxtBit = dataIn;
    if (strb.mode != MODE_PASS) begin
      unique case (strb.slot)
        SLOT_PAY: nxtBit = isAis ? ~strb.phase[0] : ~strb.phase[1];
        SLOT_X:   nxtBit = isAis ? 1'b1 : dataIn;
        SLOT_P:   nxtBit = parityIn;
        SLOT_M,
        SLOT_F:   nxtBit = strb.fixVal;
        SLOT_C:   nxtBit = (isAis && !strb.cKeep) ? 1'b0 : dataIn;
        default:  nxtBit = dataIn;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         dataOut <= 1'b0;
    else if (strb.adv) dataOut <= nxtBit;
  end

endmodule

// File: rtl/ds3_fill_gen.sv
module ds3_fill_gen
  import ds3_fill_pkg::*;
#(
  parameter int BLOCK_LEN  = 85,
  parameter int BLOCKS     = 8,
  parameter int SUBFRAMES  = 7,
  parameter int X_SUBS     = 2,
  parameter int P_SUBS     = 2,
  parameter int KEEP_C_SUB = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic frameStart,
  input  logic dataIn,
  input  logic parityIn,
  input  logic aisEn,
  input  logic idleEn,
  output logic dataOut
);

  fillStrobe_t strb;

  ds3_fill_ctrl #(
    .BLOCK_LEN(BLOCK_LEN), .BLOCKS(BLOCKS), .SUBFRAMES(SUBFRAMES),
    .X_SUBS(X_SUBS), .P_SUBS(P_SUBS), .KEEP_C_SUB(KEEP_C_SUB)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameStart(frameStart),
    .aisEn(aisEn), .idleEn(idleEn), .strb(strb)
  );

  ds3_fill_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .dataIn(dataIn), .parityIn(parityIn), .dataOut(dataOut)
  );

endmodule

// File: rtl/ds3_fill_chk.sv
module ds3_fill_chk
  import ds3_fill_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        dataIn,
  input logic        parityIn,
  input logic        aisEn,
  input logic        dataOut,
  input fillStrobe_t strb
);

  // R1: pass mode copies the accepted bit
  p_pass_copy_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strb.adv) && $past(strb.mode) == MODE_PASS
      |-> dataOut == $past(dataIn));

  // R1: output holds without an accepted bit
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(strb.adv) |-> $stable(dataOut));

  // R3: Idle payload pattern
  p_idle_pay_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strb.adv) && $past(strb.mode) == MODE_IDLE
      && $past(strb.slot) == SLOT_PAY |-> dataOut == ~$past(strb.phase[1]));

  // R4: AIS payload pattern
  p_ais_pay_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strb.adv) && $past(strb.mode) == MODE_AIS
      && $past(strb.slot) == SLOT_PAY |-> dataOut == ~$past(strb.phase[0]));

  // R7: parity slots carry the supplied parity
  p_parity_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strb.adv) && $past(strb.mode) != MODE_PASS
      && $past(strb.slot) == SLOT_P |-> dataOut == $past(parityIn));

  // R8: X slots high under AIS
  p_x_ais_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strb.adv) && $past(strb.mode) == MODE_AIS
      && $past(strb.slot) == SLOT_X |-> dataOut);

  // R10: AIS request wins at a frame boundary
  p_ais_prio_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.sof && aisEn |-> strb.mode == MODE_AIS);

  // R11: no mode change inside a frame
  p_mode_frame_r11: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strb.adv) && strb.adv && !strb.sof
      |-> strb.mode == $past(strb.mode));

endmodule

bind ds3_fill_gen ds3_fill_chk u_chk (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .parityIn(parityIn),
  .aisEn(aisEn), .dataOut(dataOut), .strb(strb)
);

// File: tb/tb_ds3_fill_gen.sv
`timescale 1ns/1ps
module tb_ds3_fill_gen;

  localparam int FRAME_BITS = 4760;
  // row: {aisEn, idleEn, dataKind[1:0]}; kind 0 pseudo-random, 1 zeros, 2 ones
  localparam logic [3:0] ROWS [6] = '{4'b0000, 4'b0100, 4'b1000,
                                      4'b1100, 4'b0101, 4'b1010};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0, frameStart = 1'b0, dataIn = 1'b0, parityIn = 1'b0;
  logic aisEn = 1'b0, idleEn = 1'b0;
  logic dataOut;

  int checks = 0;
  int errors = 0;
  int bpos = 0;
  int latched = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  ds3_fill_gen dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameStart(frameStart),
    .dataIn(dataIn), .parityIn(parityIn), .aisEn(aisEn), .idleEn(idleEn),
    .dataOut(dataOut)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pos=%0d actual=%b expected=%b", tag, bpos, act, exp);
    end
  endtask

  // model: mode 0 pass, 1 Idle, 2 AIS
  function automatic logic model(input int pos, input int md, input logic d,
                                 input logic p, output string tag);
    int b, blk, sub, k, fi;
    b = pos % 85; blk = (pos / 85) % 8; sub = pos / 680;
    if (md == 0) begin tag = "R1"; return d; end
    if (b != 0) begin
      k = b - 1;
      if (md == 1) begin tag = "R3"; return (k % 4) < 2; end
      tag = "R4"; return (k % 2) == 0;
    end
    if (blk % 2 == 1) begin
      fi = (blk - 1) / 2; tag = "R6"; return (fi == 0) || (fi == 3);
    end
    if (blk == 0) begin
      if (sub < 2) begin tag = "R8"; return (md == 2) ? 1'b1 : d; end
      if (sub < 4) begin tag = "R7"; return p; end
      tag = "R5"; return sub == 5;
    end
    tag = "R9";
    return (md == 2 && sub != 2) ? 1'b0 : d;
  endfunction

  function automatic int liveMode();
    return aisEn ? 2 : (idleEn ? 1 : 0);
  endfunction

  task automatic runBit(input logic d, input logic p, input logic fs,
                        input string force_tag);
    string tag;
    logic exp;
    if (fs) bpos = 0;
    if (bpos == 0) latched = liveMode();
    exp = model(bpos, latched, d, p, tag);
    if (liveMode() != latched) tag = "R11";
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    dataIn = d; parityIn = p; frameStart = fs; bitEn = 1'b1;
    @(posedge clk);
    #1;
    frameStart = 1'b0;
    check(dataOut, exp, tag);
    bpos = (bpos + 1) % FRAME_BITS;
  endtask

  function automatic logic pickData(input logic [1:0] kind);
    if (kind == 2'd1) return 1'b0;
    if (kind == 2'd2) return 1'b1;
    return lfsr[0];
  endfunction

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic held;
    repeat (4) @(posedge clk);
    #1;
    check(dataOut, 1'b0, "R1 reset");
    @(negedge clk);
    rstN = 1'b1;

    // frame table walk; next row's controls appear 20 bits early (R11)
    for (int r = 0; r < 6; r++) begin
      string tagR;
      tagR = (ROWS[r][3] && ROWS[r][2]) ? "R10" : "";
      aisEn = ROWS[r][3]; idleEn = ROWS[r][2];
      for (int i = 0; i < FRAME_BITS; i++) begin
        if (i == FRAME_BITS - 20 && r < 5) begin
          aisEn = ROWS[r + 1][3]; idleEn = ROWS[r + 1][2];
        end
        runBit(pickData(ROWS[r][1:0]), lfsr[5], (r == 0 && i == 0),
               (i < FRAME_BITS - 20) ? tagR : "");
        stepLfsr();
      end
    end

    // R1: output holds while no bit is accepted
    @(negedge clk);
    bitEn = 1'b0;
    dataIn = ~dataOut;
    held = dataOut;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      check(dataOut, held, "R1 hold");
    end

    // R2: resynchronise mid-frame into AIS, then check 700 bits
    aisEn = 1'b0; idleEn = 1'b0;
    for (int i = 0; i < 300; i++) begin
      runBit(lfsr[0], lfsr[3], 1'b0, "");
      stepLfsr();
    end
    aisEn = 1'b1;
    for (int i = 0; i < 700; i++) begin
      runBit(lfsr[0], lfsr[3], (i == 0), "R2");
      stepLfsr();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule